// File: doc/BRIEF.md
# Infrared Raw Pulse-Width Capture Engine

This block samples the output of an infrared receiver and turns the waveform into a stream of width pairs. The receiver output is active low. A low stretch is the mark and the high stretch after it is the space. Each pair forms one symbol. Widths are counted in 10 µs units. The base for those units is a programmable prescaler that divides the input clock down to a 1 µs tick. Every finished symbol is pushed into a small receive queue, and software reads it back through a word-indexed register port.

Capture needs three conditions: the engine is enabled, its short initialisation window has finished, and software has written the start register. While the line is high, a stream ends once mark plus space reaches a programmable limit. The engine then pushes the last symbol with a clipped space and raises a timeout flag. Three sticky flags (queue level, timeout, overflow) can each be masked and drive a single interrupt line. On overflow the stored symbols stay intact so that software can drain them.

Top module: `ir_symbol_rx`

## Requirements
- R1: Register index (addr_i): 0 enable, 1 configuration, 2 busy, 3 count, 4 data, 5 mask, 6 status, 7 clear, 8 start. After reset the count and status read 0, irq_o is 0 and the mask reads 7.
- R2: Writing 1 to bit 0 of the enable register makes the busy register read nonzero for INIT_CYC cycles. After that it reads 0.
- R3: No symbol is captured before any write to the start register, whatever the line does.
- R4: A symbol word holds the mark (low time) width in bits 15:0 and the following space (high time) width in bits 31:16. Each width is the elapsed time divided by 10*(P+1) clock cycles and rounded down, where P is the prescale field. The word is pushed at the next falling edge.
- R5: If the space grows until mark plus space equals the maximum width, the symbol is pushed with space = maximum - mark. The timeout flag (status bit 25) is set, and a line resting high adds no further symbols.
- R6: The count register returns the number of queued symbols. Each data read pops the oldest symbol. A data read from an empty queue returns 0 and changes nothing.
- R7: The received flag (status bit 24) sets when the count reaches the level field plus one, and not before.
- R8: The queue holds DEPTH (16) symbols. A push into a full queue is dropped and sets the overflow flag (status bit 26). The stored symbols survive, and the flag stays set after draining until it is cleared.
- R9: Writing 1 to clear-register bits 16, 17 or 18 clears the received, timeout or overflow flag. Zero bits have no effect.
- R10: Mask bits 0, 1 and 2 (1 = masked) gate received, timeout and overflow. Status bits 8 to 10 show the unmasked flags. irq_o is the OR of those bits while the engine is enabled.
- R11: Configuration fields are 31:16 maximum width, 15:14 format, 13:8 level, 7 raw select and 6:0 prescale. The register reads back as written, and its reset value is 0x3E800080. With bit 7 at 0 nothing is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ir_i | input | 1 | Infrared receiver output, asynchronous, low = mark |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe (pops on data index) |
| addr_i | input | 4 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational on addr_i |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that the queue count never exceeds its depth, that a pop lowers the count by exactly one, and that no symbol is pushed unless capture was active the cycle before. They also check that a timeout push or a dropped push always raises its sticky flag, and that the interrupt never fires while the engine is disabled. The bench scenarios cover what the assertions cannot: exact width packing and rounding under two prescale settings, FIFO ordering, the clipped space of a timed-out symbol, the level threshold, survival of the stored symbols after an overflow, and each register field taking effect.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;
  typedef enum logic [3:0] {
    REG_EN    = 4'd0,
    REG_CFG   = 4'd1,
    REG_BUSY  = 4'd2,
    REG_CNT   = 4'd3,
    REG_DATA  = 4'd4,
    REG_MASK  = 4'd5,
    REG_STAT  = 4'd6,
    REG_CLR   = 4'd7,
    REG_START = 4'd8
  } reg_idx_e;

  typedef enum logic [1:0] {ST_IDLE, ST_MARK, ST_SPACE} cap_state_e;

  typedef struct packed {
    logic [15:0] maxw;
    logic [1:0]  fmt;
    logic [5:0]  lvl;
    logic        raw;
    logic [6:0]  presc;
  } cfg_t;

  localparam logic [31:0] CFG_RESET = 32'h3E80_0080;
  localparam int NFLAG = 3;
endpackage

// File: rtl/ir_rx_timing.sv
module ir_rx_timing
  import ir_rx_pkg::*;
#(
  parameter int CW = 16,
  parameter int PW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ir_i,
  input  logic          active_i,
  input  logic [PW-1:0] presc_i,
  input  logic [CW-1:0] maxw_i,
  output logic          push_o,
  output logic          tmo_o,
  output logic [2*CW-1:0] word_o
);
  localparam logic [3:0] DEC_LAST = 4'd9;

  logic sync1_q, sync2_q, lvl_q;
  logic fall, rise, unit, hit;
  logic [PW-1:0] pre_q;
  logic [3:0] dec_q;
  logic [CW-1:0] mark_q, space_q;
  cap_state_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      lvl_q   <= 1'b1;
    end else begin
      sync1_q <= ir_i;
      sync2_q <= sync1_q;
      lvl_q   <= sync2_q;
    end
  end

  assign fall = lvl_q & ~sync2_q;
  assign rise = ~lvl_q & sync2_q;
  assign unit = (pre_q == presc_i) && (dec_q == DEC_LAST);
  assign hit  = ({1'b0, mark_q} + {1'b0, space_q}) >= {1'b0, maxw_i};

  // Phase restarts on each edge so widths round down from the edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      dec_q <= '0;
    end else if (!active_i || fall || rise) begin
      pre_q <= '0;
      dec_q <= '0;
    end else if (pre_q == presc_i) begin
      pre_q <= '0;
      dec_q <= (dec_q == DEC_LAST) ? 4'd0 : dec_q + 4'd1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      mark_q  <= '0;
      space_q <= '0;
    end else if (!active_i) begin
      st_q    <= ST_IDLE;
      mark_q  <= '0;
      space_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (fall) begin
          st_q    <= ST_MARK;
          mark_q  <= '0;
          space_q <= '0;
        end
        ST_MARK: begin
          if (rise) begin
            st_q    <= ST_SPACE;
            space_q <= '0;
          end else if (unit && mark_q != '1) begin
            mark_q <= mark_q + 1'b1;
          end
        end
        ST_SPACE: begin
          if (fall) begin
            st_q    <= ST_MARK;
            mark_q  <= '0;
            space_q <= '0;
          end else if (hit) begin
            st_q <= ST_IDLE;
          end else if (unit && space_q != '1) begin
            space_q <= space_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign push_o = active_i && (st_q == ST_SPACE) && (fall || hit);
  assign tmo_o  = active_i && (st_q == ST_SPACE) && !fall && hit;
  assign word_o = {space_q, mark_q};

  // R5
  tmo_ends_stream_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o |=> !push_o);
endmodule

// File: rtl/ir_rx_fifo.sv
module ir_rx_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   push_i,
  input  logic [DW-1:0]          data_i,
  input  logic                   pop_i,
  output logic [DW-1:0]          head_o,
  output logic [$clog2(DEPTH):0] count_o,
  output logic                   full_o,
  output logic                   drop_o
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [AW:0]   cnt_q;
  logic do_push, do_pop;

  assign full_o  = (cnt_q == DEPTH[AW:0]);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && (cnt_q != '0);
  assign drop_o  = push_i && full_o;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  assign head_o  = (cnt_q != '0) ? mem_q[rd_q] : '0;
  assign count_o = cnt_q;

  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= DEPTH[AW:0]);
  // R6
  pop_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/ir_rx_irq.sv
module ir_rx_irq
  import ir_rx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [NFLAG-1:0] set_i,
  input  logic [NFLAG-1:0] clr_i,
  input  logic [NFLAG-1:0] mask_i,
  output logic [NFLAG-1:0] raw_o,
  output logic [NFLAG-1:0] pend_o,
  output logic             irq_o
);
  logic [NFLAG-1:0] raw_q;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    // set wins over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       raw_q[i] <= 1'b0;
      else if (set_i[i]) raw_q[i] <= 1'b1;
      else if (clr_i[i]) raw_q[i] <= 1'b0;
    end
  end

  assign raw_o  = raw_q;
  assign pend_o = raw_q & ~mask_i;
  assign irq_o  = en_i && (|pend_o);
endmodule

// File: rtl/ir_symbol_rx.sv
module ir_symbol_rx
  import ir_rx_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int INIT_CYC = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ir_i,
  input  logic        we_i,
  input  logic        re_i,
  input  logic [3:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o
);
  localparam int CNTW = $clog2(DEPTH) + 1;
  localparam int BW   = $clog2(INIT_CYC + 1);

  cfg_t cfg_q;
  logic en_q, run_q;
  logic [BW-1:0] busy_q;
  logic [NFLAG-1:0] mask_q, clr, set, raw, pend;
  logic cap_active, sym_push, sym_tmo, fifo_full, fifo_drop, pop;
  logic [31:0] sym_word, head;
  logic [CNTW-1:0] count;
  reg_idx_e idx;

  assign idx = reg_idx_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= cfg_t'(CFG_RESET);
      en_q   <= 1'b0;
      run_q  <= 1'b0;
      busy_q <= '0;
      mask_q <= '1;
    end else begin
      if (we_i && idx == REG_EN && wdata_i[0]) busy_q <= BW'(INIT_CYC);
      else if (busy_q != '0)                    busy_q <= busy_q - 1'b1;
      if (we_i) begin
        unique case (idx)
          REG_EN: begin
            en_q <= wdata_i[0];
            if (!wdata_i[0]) run_q <= 1'b0;
          end
          REG_CFG:   cfg_q  <= cfg_t'(wdata_i);
          REG_MASK:  mask_q <= wdata_i[NFLAG-1:0];
          REG_START: run_q  <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign cap_active = en_q && run_q && (busy_q == '0) && cfg_q.raw;
  assign pop        = re_i && (idx == REG_DATA);
  assign clr        = (we_i && idx == REG_CLR) ? wdata_i[18:16] : '0;
  assign set[0]     = ({2'b0, count} >= ({1'b0, cfg_q.lvl} + 7'd1));
  assign set[1]     = sym_tmo;
  assign set[2]     = fifo_drop;

  ir_rx_timing #(.CW(16), .PW(7)) u_timing (
    .clk_i, .rst_ni, .ir_i,
    .active_i(cap_active), .presc_i(cfg_q.presc), .maxw_i(cfg_q.maxw),
    .push_o(sym_push), .tmo_o(sym_tmo), .word_o(sym_word)
  );

  ir_rx_fifo #(.DW(32), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_i(sym_push), .data_i(sym_word), .pop_i(pop),
    .head_o(head), .count_o(count), .full_o(fifo_full), .drop_o(fifo_drop)
  );

  ir_rx_irq u_irq (
    .clk_i, .rst_ni, .en_i(en_q), .set_i(set), .clr_i(clr), .mask_i(mask_q),
    .raw_o(raw), .pend_o(pend), .irq_o
  );

  always_comb begin
    rdata_o = '0;
    unique case (idx)
      REG_EN:   rdata_o[0] = en_q;
      REG_CFG:  rdata_o = cfg_q;
      REG_BUSY: rdata_o[0] = (busy_q != '0);
      REG_CNT:  rdata_o[CNTW-1:0] = count;
      REG_DATA: rdata_o = head;
      REG_MASK: rdata_o[NFLAG-1:0] = mask_q;
      REG_STAT: begin
        rdata_o[26:24] = raw;
        rdata_o[10:8]  = pend;
      end
      default: ;
    endcase
  end

  // R3
  no_capture_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_active |=> !sym_push);
  // R5
  tmo_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_tmo |=> raw[1]);
  // R8
  ovf_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_push && fifo_full) |=> raw[2]);
  // R10
  irq_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> en_q);
endmodule

// File: tb/sim_ir_symbol_rx.sv
module sim_ir_symbol_rx;
  localparam int EN = 0, CFG = 1, BUSY = 2, CNT = 3, DATA = 4, MASK = 5, STAT = 6, CLR = 7, START = 8;
  localparam int MAXW = 30;

  logic clk = 1'b0, rst_n = 1'b0, ir = 1'b1, we = 1'b0, re = 1'b0, irq;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata, v;
  int checks = 0, errors = 0;
  logic [31:0] exp_w [32];
  int exp_n = 0;

  always #2 clk = ~clk;

  ir_symbol_rx u0 (.clk_i(clk), .rst_ni(rst_n), .ir_i(ir), .we_i(we), .re_i(re),
                   .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = 4'(a); wdata = d;
    @(posedge clk); #1 we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); re = 1'b1; addr = 4'(a); #1 d = rdata;
    @(posedge clk); #1 re = 1'b0;
  endtask

  function automatic int dur(input int w, input int p);
    return 10 * (p + 1) * w + 5 * (p + 1);
  endfunction

  task automatic hold(input logic lvl, input int n);
    @(negedge clk); ir = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic burst(input int n, input int p);
    for (int i = 0; i < n; i++) begin
      int m, s;
      m = 1 + int'($urandom % 12);
      s = 1 + int'($urandom % 12);
      hold(1'b0, dur(m, p));
      if (i < n - 1) begin
        hold(1'b1, dur(s, p));
      end else begin
        s = MAXW - m;
        hold(1'b1, 10 * (p + 1) * (MAXW + 4));
      end
      if (exp_n < 16) begin
        exp_w[exp_n] = {16'(s), 16'(m)};
        exp_n++;
      end
    end
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < exp_n; i++) begin
      rd(DATA, v); chk(v, exp_w[i], tag);
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, R11 config reset value
    rd(CNT, v);  chk(v, 0, "R1 count");
    rd(STAT, v); chk(v, 0, "R1 status");
    chk(32'(irq), 0, "R1 irq");
    rd(MASK, v); chk(v, 7, "R1 mask");
    rd(CFG, v);  chk(v, 32'h3E80_0080, "R11 cfg reset");
    // R2 busy window
    wr(EN, 1);
    rd(BUSY, v); chk(32'(v != 0), 1, "R2 busy set");
    repeat (20) @(negedge clk);
    rd(BUSY, v); chk(v, 0, "R2 busy done");
    wr(CFG, (MAXW << 16) | (3 << 8) | 32'h80);
    rd(CFG, v);  chk(v, (MAXW << 16) | (3 << 8) | 32'h80, "R11 readback");
    wr(MASK, 0);
    // R3 no capture before start
    repeat (3) begin hold(1'b0, 60); hold(1'b1, 60); end
    rd(CNT, v); chk(v, 0, "R3 pre-start");
    wr(START, 1);
    // R4 R5 R6 R7: three symbols, level 4 not reached
    exp_n = 0; burst(3, 0);
    rd(CNT, v);  chk(v, 3, "R6 count");
    rd(STAT, v); chk(v, (1 << 25) | (1 << 9), "R5 R7 status");
    chk(32'(irq), 1, "R10 irq on timeout");
    drain("R4 R5 symbol");
    rd(DATA, v); chk(v, 0, "R6 empty read");
    rd(CNT, v);  chk(v, 0, "R6 empty count");
    // R9 clear
    wr(CLR, 0);
    rd(STAT, v); chk(v, (1 << 25) | (1 << 9), "R9 zero write");
    wr(CLR, 1 << 17);
    rd(STAT, v); chk(v, 0, "R9 clear tmo");
    chk(32'(irq), 0, "R9 irq low");
    // R7 level reached, R10 mask
    exp_n = 0; burst(5, 0);
    rd(STAT, v); chk(v, (3 << 24) | (3 << 8), "R7 rcv set");
    wr(MASK, 3);
    rd(STAT, v); chk(v, 3 << 24, "R10 masked status");
    chk(32'(irq), 0, "R10 masked irq");
    wr(MASK, 0);
    drain("R4 R6 order");
    wr(CLR, 32'h7_0000);
    rd(STAT, v); chk(v, 0, "R9 clear all");
    // R8 overflow
    exp_n = 0; burst(18, 0);
    rd(CNT, v);  chk(v, 16, "R8 full count");
    rd(STAT, v); chk((v >> 24) & 7, 7, "R8 flags");
    drain("R8 kept data");
    rd(STAT, v); chk((v >> 26) & 1, 1, "R8 sticky ovf");
    wr(CLR, 1 << 18);
    rd(STAT, v); chk((v >> 26) & 1, 0, "R8 R9 ovf cleared");
    wr(CLR, 32'h7_0000);
    // R4 prescale 1
    wr(CFG, (MAXW << 16) | 32'h80 | 1);
    exp_n = 0; burst(2, 1);
    rd(CNT, v); chk(v, 2, "R4 presc count");
    drain("R4 presc symbol");
    wr(CLR, 32'h7_0000);
    // R11 raw select off
    wr(CFG, (MAXW << 16) | 1);
    repeat (2) begin hold(1'b0, 60); hold(1'b1, 400); end
    rd(CNT, v); chk(v, 0, "R11 raw off");
    // R10 irq gated by enable
    wr(CFG, (MAXW << 16) | 32'h80);
    exp_n = 0; burst(1, 0);
    chk(32'(irq), 1, "R10 irq pending");
    wr(EN, 0);
    chk(32'(irq), 0, "R10 irq disabled");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule